// File: doc/BRIEF.md
# Dot-Product Column Cell

This cell computes one column of a matrix product, the building block of an 8-point one-dimensional transform done as a matrix multiply. A small local memory holds one column of the weight matrix. The column is written over the same input stream that later carries the matrix elements. While the column-load input is high, each valid beat is written into the next memory slot. Afterwards, the rows of the input matrix stream in one element per valid beat, in row-major order. For each beat the cell multiplies the element by the weight at the current address, scales the product, and folds the result into a running dot product.

An address counter steps by one on every valid beat. It returns to zero when the row-end marker is seen, and it also wraps after the last slot. A beat that lands on address zero starts a fresh sum, so the cell needs no clear cycle between rows. On the beat that carries the row-end marker, the finished dot product is inserted into a two-register result chain. When the cell is not inserting, the chain carries results from the upstream neighbour. The cell also repeats its input stream one cycle later, which lets a string of cells form a systolic array: each cell finishes its row one cycle after its upstream neighbour, and the chain then delivers the results in row-major order.

Top module: `dot_column_cell`

## Requirements
- R1: After reset, chainOutValid and fwdValid are low, and the local address is zero.
- R2: A valid beat with colLoad high writes inData into the weight slot at the current address and never produces a result on the chain.
- R3: Each valid beat advances the address by one, wrapping from DEPTH-1 to zero. Cycles with inValid low change neither the address nor the running sum, so idle gaps inside a row do not alter its result.
- R4: Each compute beat (inValid high, colLoad low) contributes the signed 32-bit product of inData and the addressed weight. This product is shifted right arithmetically by FRAC_SHIFT (8), sign-extended to ACC_W, and summed modulo 2^ACC_W.
- R5: A compute beat at address zero loads its own term into the sum instead of adding it to the previous sum. This holds after the row-end marker and after a wrap.
- R6: On a compute beat with rowEnd high, the sum including that beat appears on chainOutData with chainOutValid high exactly two clock edges later, and the address returns to zero. A short row therefore sums only the weights it reached.
- R7: When the cell is not inserting a result, chainInValid and chainInData reach chainOutValid and chainOutData exactly two clock edges later.
- R8: fwdValid, fwdData and fwdRowEnd repeat inValid, inData and rowEnd one clock edge later.
- R9: A full 8x8 matrix streamed back to back in row-major order yields eight results, in row order, each equal to the reference dot product of its row with the stored column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A beat is present on inData |
| colLoad | input | 1 | Beat is a weight to store, not a matrix element |
| rowEnd | input | 1 | Beat is the last element of its row |
| inData | input | DATA_W (16) | Signed weight or matrix element |
| chainInValid | input | 1 | Upstream result slot is occupied |
| chainInData | input | ACC_W (32) | Upstream result value |
| fwdValid | output | 1 | Input valid delayed by one cycle |
| fwdRowEnd | output | 1 | Row-end marker delayed by one cycle |
| fwdData | output | DATA_W (16) | Input data delayed by one cycle |
| chainOutValid | output | 1 | Result slot toward downstream is occupied |
| chainOutData | output | ACC_W (32) | Result value toward downstream |

## Verification
The assertions check the following on every cycle:
- the address counter stays in range;
- the address steps by one on each valid beat, stays put when no beat arrives, and returns to zero after a row end;
- every row end reaches the chain output two edges later;
- the forward stage repeats the input;
- no row end meets an occupied upstream slot.

The arithmetic can only be shown by the bench's scenarios, because it depends on the stored column and the streamed data. These scenarios cover the signed scaling, the fresh start at address zero after a row end or a wrap, short rows, idle gaps inside a row, and the full 8x8 product in row order.

// File: rtl/dot_cell_pkg.sv
package dot_cell_pkg;
  // Strobes from the control to the datapath, valid for the current beat.
  typedef struct packed {
    logic wrWeight; // store inData at the current address
    logic macEn;    // fold a product into the running sum
    logic first;    // current address is zero: start a fresh sum
    logic emit;     // finished sum goes into the result chain
  } cellCtrl_t;
endpackage

// File: rtl/dot_cell_ctrl.sv
module dot_cell_ctrl
  import dot_cell_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              colLoad,
  input  logic              rowEnd,
  output logic [ADDR_W-1:0] addr,
  output cellCtrl_t         ctrl
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr <= '0;
    end else if (inValid) begin
      if (rowEnd || addr == LAST_ADDR) addr <= '0;
      else                             addr <= addr + 1'b1;
    end
  end

  always_comb begin
    ctrl.wrWeight = inValid && colLoad;
    ctrl.macEn    = inValid && !colLoad;
    ctrl.first    = (addr == '0);
    ctrl.emit     = inValid && !colLoad && rowEnd;
  end
endmodule

// File: rtl/dot_cell_datapath.sv
module dot_cell_datapath
  import dot_cell_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ACC_W      = 32,
  parameter int DEPTH      = 8,
  parameter int FRAC_SHIFT = 8,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cellCtrl_t                ctrl,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     inValid,
  input  logic                     rowEnd,
  input  logic signed [DATA_W-1:0] inData,
  input  logic                     chainInValid,
  input  logic signed [ACC_W-1:0]  chainInData,
  output logic                     fwdValid,
  output logic                     fwdRowEnd,
  output logic signed [DATA_W-1:0] fwdData,
  output logic                     chainOutValid,
  output logic signed [ACC_W-1:0]  chainOutData
);
  localparam int PROD_W      = 2 * DATA_W;
  localparam int CHAIN_DEPTH = 2;

  logic signed [DATA_W-1:0] wMem [DEPTH];
  logic signed [DATA_W-1:0] wSel;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;
  logic signed [ACC_W-1:0]  term;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  sum;

  // Local weight column.
  always_ff @(posedge clk) begin
    if (ctrl.wrWeight) wMem[addr] <= inData;
  end

  // Multiply, scale, accumulate.
  always_comb begin
    wSel   = wMem[addr];
    prod   = inData * wSel;
    scaled = prod >>> FRAC_SHIFT;
    term   = ACC_W'(scaled);
    sum    = ctrl.first ? term : acc + term;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           acc <= '0;
    else if (ctrl.macEn) acc <= sum;
  end

  // Input stream repeated one cycle later for the next cell.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdValid  <= 1'b0;
      fwdRowEnd <= 1'b0;
      fwdData   <= '0;
    end else begin
      fwdValid  <= inValid;
      fwdRowEnd <= rowEnd;
      fwdData   <= inData;
    end
  end

  // Result chain: the first slot takes our sum or the neighbour's, later slots shift.
  logic                    slotV [CHAIN_DEPTH];
  logic signed [ACC_W-1:0] slotD [CHAIN_DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotV[0] <= 1'b0;
      slotD[0] <= '0;
    end else if (ctrl.emit) begin
      slotV[0] <= 1'b1;
      slotD[0] <= sum;
    end else begin
      slotV[0] <= chainInValid;
      slotD[0] <= chainInData;
    end
  end

  for (genvar s = 1; s < CHAIN_DEPTH; s++) begin : gChain
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotV[s] <= 1'b0;
        slotD[s] <= '0;
      end else begin
        slotV[s] <= slotV[s-1];
        slotD[s] <= slotD[s-1];
      end
    end
  end

  assign chainOutValid = slotV[CHAIN_DEPTH-1];
  assign chainOutData  = slotD[CHAIN_DEPTH-1];
endmodule

// File: rtl/dot_column_cell.sv
module dot_column_cell
  import dot_cell_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ACC_W      = 32,
  parameter int DEPTH      = 8,
  parameter int FRAC_SHIFT = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic                     colLoad,
  input  logic                     rowEnd,
  input  logic signed [DATA_W-1:0] inData,
  input  logic                     chainInValid,
  input  logic signed [ACC_W-1:0]  chainInData,
  output logic                     fwdValid,
  output logic                     fwdRowEnd,
  output logic signed [DATA_W-1:0] fwdData,
  output logic                     chainOutValid,
  output logic signed [ACC_W-1:0]  chainOutData
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] addr;
  cellCtrl_t         ctrl;

  dot_cell_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .colLoad(colLoad),
    .rowEnd(rowEnd), .addr(addr), .ctrl(ctrl)
  );

  dot_cell_datapath #(
    .DATA_W(DATA_W), .ACC_W(ACC_W), .DEPTH(DEPTH), .FRAC_SHIFT(FRAC_SHIFT)
  ) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .addr(addr),
    .inValid(inValid), .rowEnd(rowEnd), .inData(inData),
    .chainInValid(chainInValid), .chainInData(chainInData),
    .fwdValid(fwdValid), .fwdRowEnd(fwdRowEnd), .fwdData(fwdData),
    .chainOutValid(chainOutValid), .chainOutData(chainOutData)
  );
endmodule

// File: rtl/dot_column_cell_chk.sv
module dot_column_cell_chk #(
  parameter int DEPTH = 8,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              colLoad,
  input logic              rowEnd,
  input logic              chainInValid,
  input logic              chainOutValid,
  input logic              fwdValid,
  input logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    addr <= LAST_ADDR); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !rowEnd && addr != LAST_ADDR) |=> addr == ADDR_W'($past(addr) + 1'b1)); // R3

  AST_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(addr)); // R3

  AST_ROW_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && rowEnd) |=> addr == '0); // R6

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !colLoad && rowEnd) |-> ##2 chainOutValid); // R6

  AST_NO_SLOT_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !colLoad && rowEnd) |-> !chainInValid); // R6

  AST_FWD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> fwdValid); // R8

  AST_FWD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !fwdValid); // R8
endmodule

bind dot_column_cell dot_column_cell_chk #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .colLoad(colLoad),
  .rowEnd(rowEnd), .chainInValid(chainInValid),
  .chainOutValid(chainOutValid), .fwdValid(fwdValid), .addr(addr)
);

// File: tb/dot_column_cell_test.sv
module dot_column_cell_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, colLoad = 1'b0, rowEnd = 1'b0;
  logic signed [15:0] inData = '0;
  logic chainInValid = 1'b0;
  logic signed [31:0] chainInData = '0;
  logic fwdValid, fwdRowEnd, chainOutValid;
  logic signed [15:0] fwdData;
  logic signed [31:0] chainOutData;

  int nRun = 0, nFail = 0;
  bit done = 1'b0;
  int wCol [8];
  int rowBuf [9];
  int mat [8][8];
  int resData [64];
  int resCnt = 0;

  always #4 clk = ~clk;

  dot_column_cell uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .colLoad(colLoad),
    .rowEnd(rowEnd), .inData(inData), .chainInValid(chainInValid),
    .chainInData(chainInData), .fwdValid(fwdValid), .fwdRowEnd(fwdRowEnd),
    .fwdData(fwdData), .chainOutValid(chainOutValid), .chainOutData(chainOutData)
  );

  // Result collector, sampled shortly after each edge.
  always @(posedge clk) begin
    #1;
    if (rstN && chainOutValid && resCnt < 64) begin
      resData[resCnt] = chainOutData;
      resCnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  function automatic int termOf(input int x, input int w);
    int p;
    p = x * w;
    return p >>> 8;
  endfunction

  task automatic beat(input logic ld, input int d, input logic re);
    @(negedge clk);
    inValid = 1'b1; colLoad = ld; rowEnd = re; inData = 16'(d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; colLoad = 1'b0; rowEnd = 1'b0;
    end
  endtask

  // Streams rowBuf[0..len-1] with `gap` idle cycles between beats, checks one result.
  task automatic runRow(input string req, input int len, input int gap);
    int base, exp;
    base = resCnt;
    exp = 0;
    for (int i = 0; i < len; i++) begin
      beat(1'b0, rowBuf[i], i == len - 1);
      exp += termOf(rowBuf[i], wCol[i]);
      if (i != len - 1) idle(gap);
    end
    idle(3);
    chk({req, " result count"}, resCnt - base, 1);
    chk({req, " result value"}, resData[base], exp);
  endtask

  task automatic tReset();
    @(negedge clk);
    chk("R1 chainOutValid after reset", int'(chainOutValid), 0);
    chk("R1 fwdValid after reset", int'(fwdValid), 0);
  endtask

  task automatic tLoad();
    int base;
    base = resCnt;
    for (int i = 0; i < 8; i++) begin
      wCol[i] = ((i * 71) % 401) - 200;
      beat(1'b1, wCol[i], 1'b0);
    end
    idle(1);
    beat(1'b1, wCol[0], 1'b1); // row end during load: no result, address back to 0
    idle(3);
    chk("R2 no result from weight beats", resCnt - base, 0);
  endtask

  task automatic tMatrix();
    int base;
    base = resCnt;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin
        mat[r][c] = (((r * 8 + c) * 97) % 511) - 255;
        beat(1'b0, mat[r][c], c == 7);
      end
    idle(3);
    chk("R9 row count", resCnt - base, 8);
    for (int r = 0; r < 8; r++) begin
      int exp;
      exp = 0;
      for (int c = 0; c < 8; c++) exp += termOf(mat[r][c], wCol[c]);
      chk("R9 R4 R5 row result", resData[base + r], exp);
    end
  endtask

  task automatic tBubbles();
    for (int i = 0; i < 8; i++) rowBuf[i] = 300 - i * 77;
    runRow("R3 idle gaps", 8, 2);
  endtask

  task automatic tShort();
    for (int i = 0; i < 8; i++) rowBuf[i] = 1000 + i * 13;
    runRow("R6 short row", 3, 0);
    for (int i = 0; i < 8; i++) rowBuf[i] = -500 + i * 3;
    runRow("R5 after short row", 8, 0);
  endtask

  task automatic tNegative();
    for (int i = 0; i < 8; i++) rowBuf[i] = -3 - i * 1000;
    runRow("R4 negative rounding", 8, 0);
  endtask

  task automatic tWrap();
    int base;
    base = resCnt;
    for (int i = 0; i < 8; i++) beat(1'b0, 500 + i, 1'b0);
    beat(1'b0, 1234, 1'b1); // lands on address 0 after the wrap
    idle(3);
    chk("R5 R3 fresh sum after wrap", resData[base], termOf(1234, wCol[0]));
  endtask

  task automatic tChain();
    int base;
    base = resCnt;
    @(negedge clk);
    chainInValid = 1'b1; chainInData = 32'sh1234_5678;
    @(negedge clk);
    chainInValid = 1'b0; chainInData = '0;
    chk("R7 chain not yet out after one edge", int'(chainOutValid), 0);
    @(negedge clk);
    chk("R7 chain out after two edges", int'(chainOutValid), 1);
    chk("R7 chain data forwarded", chainOutData, 32'sh1234_5678);
    idle(2);
    chk("R7 single chain entry", resCnt - base, 1);
  endtask

  task automatic tForward();
    int base;
    base = resCnt;
    beat(1'b0, 77, 1'b1);
    @(negedge clk);
    chk("R8 fwdValid", int'(fwdValid), 1);
    chk("R8 fwdData", int'(fwdData), 77);
    chk("R8 fwdRowEnd", int'(fwdRowEnd), 1);
    inValid = 1'b0; rowEnd = 1'b0;
    @(negedge clk);
    chk("R8 fwdValid drops", int'(fwdValid), 0);
    idle(2);
    chk("R6 one-beat row", resData[base], termOf(77, wCol[0]));
  endtask

  initial begin
    #(8 * 100000);
    nFail++;
    nRun++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tLoad();
    tMatrix();
    tBubbles();
    tShort();
    tNegative();
    tWrap();
    tChain();
    tForward();
    idle(2);
    finishRun();
  end
endmodule